// File: doc/BRIEF.md
# Wide Free-Running Timer with Self-Rearming Comparator

This block is a memory-mapped system timer. Its core is a 64-bit up-counter that advances once per clock while started, rolls over at the full 64-bit range, and is reached over a 32-bit register bus as a low half and a high half. Software gets a consistent 64-bit value by reading the high half, then the low half, then the high half again, and retrying if the two high values differ.

A single 64-bit comparator watches the counter. When it is enabled and the counter equals the programmed compare value, a sticky event flag is raised. The interrupt output is that flag gated by an enable bit. In periodic mode the comparator adds a 32-bit step to its own compare value on every match, so events recur at a fixed spacing without software help.

Every write to the counter, compare, step or control registers is reported by its own commit bit a fixed number of clock cycles after the write lands. This models the settle time of a slower timer clock. Software polls that bit and clears it by writing 1. The bus is a plain address, write-data, write-enable and combinational read-data interface.

Top module: `wide_tick_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and does not move, and `irq` is low.
- R2: Compare low (0x200), compare high (0x204) and step (0x208) read back all 32 written bits. Control (0x240) reads back only bit 8 (run), bit 1 (auto-step) and bit 0 (compare enable), with all other bits zero. The interrupt mask (0x248) reads back only bit 0. Any undefined offset reads zero, and a write to one has no visible effect.
- R3: A write to 0x100 or 0x104 loads that half of the counter. While control bit 8 is 0, the counter holds its value.
- R4: While control bit 8 is 1 and no counter half is being written, the counter adds one per clock, carries from the low half into the high half, and wraps from all ones to zero.
- R5: Exactly 2 clock edges after the edge that takes a write, its commit bit is set. Register 0x110 uses bit 0 for the counter low half and bit 1 for the counter high half. Register 0x24C uses bit 0 for compare low, bit 1 for compare high, bit 2 for step and bit 16 for control.
- R6: Writing 1 to a commit bit clears it, and bits written 0 are left alone. When a commit bit is being set and cleared on the same edge, it ends up set.
- R7: Writes to the mask, the event flag, either commit register or an undefined offset set no commit bit.
- R8: When control bit 0 is 1 and the counter equals the 64-bit compare value, bit 0 of the event flag register (0x244) is set on the next edge. `irq` equals that flag ANDed with mask bit 0.
- R9: The event flag stays set after the match has passed. With mask bit 0 cleared, `irq` is low while the flag still reads 1.
- R10: Writing 1 to bit 0 of 0x244 clears the flag. If a match occurs on the same edge, the flag stays set.
- R11: With control bit 1 set, each match adds the step to the compare value on the same edge that sets the flag, so matches recur every step cycles.
- R12: With control bit 0 clear, a counter that passes the compare value raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt: event flag AND mask bit 0 |

## Verification
The sharpest overlap is a comparator match and a software write-1-to-clear of the event flag landing on the same clock edge. The bench runs the comparator in periodic mode and times its clear write so that the write edge coincides with the second match. It then expects the flag still to read 1 and the compare value already advanced by the step, and a second clear one cycle later must succeed. The same set-against-clear race is also provoked on a commit bit by clearing it on exactly the edge its delayed set arrives.

// File: rtl/wtt_pkg.sv
package wtt_pkg;

    localparam int HALF_W   = 32;
    localparam int N_HALVES = 2;
    localparam int CNT_W    = HALF_W * N_HALVES;
    localparam int ADDR_W   = 12;

    // Register offsets (software decodes these)
    localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_CNT_ACK = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO  = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI  = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_STEP    = 12'h208;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h240;
    localparam logic [ADDR_W-1:0] OFS_FLAG    = 12'h244;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 12'h248;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h24C;

    // Field positions
    localparam int CTRL_RUN_BIT   = 8;
    localparam int CTRL_AUTO_BIT  = 1;
    localparam int CTRL_CMPEN_BIT = 0;
    localparam int ACK_CTRL_BIT   = 16;
    localparam int ACK_STEP_BIT   = 2;
    localparam int ACK_CMPHI_BIT  = 1;
    localparam int ACK_CMPLO_BIT  = 0;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_CNT_ACK,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_STEP,
        SEL_CTRL,
        SEL_FLAG,
        SEL_MASK,
        SEL_ACK
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic auto_inc;
        logic cmp_en;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic step;
        logic cmp_hi;
        logic cmp_lo;
        logic cnt_hi;
        logic cnt_lo;
    } commit_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CNT_LO:  s = SEL_CNT_LO;
            OFS_CNT_HI:  s = SEL_CNT_HI;
            OFS_CNT_ACK: s = SEL_CNT_ACK;
            OFS_CMP_LO:  s = SEL_CMP_LO;
            OFS_CMP_HI:  s = SEL_CMP_HI;
            OFS_STEP:    s = SEL_STEP;
            OFS_CTRL:    s = SEL_CTRL;
            OFS_FLAG:    s = SEL_FLAG;
            OFS_MASK:    s = SEL_MASK;
            OFS_ACK:     s = SEL_ACK;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [HALF_W-1:0] w);
        ctrl_t c;
        c.run      = w[CTRL_RUN_BIT];
        c.auto_inc = w[CTRL_AUTO_BIT];
        c.cmp_en   = w[CTRL_CMPEN_BIT];
        return c;
    endfunction

    function automatic logic [HALF_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [HALF_W-1:0] w;
        w = '0;
        w[CTRL_RUN_BIT]   = c.run;
        w[CTRL_AUTO_BIT]  = c.auto_inc;
        w[CTRL_CMPEN_BIT] = c.cmp_en;
        return w;
    endfunction

    // Which commit bit a write to a given register produces
    function automatic commit_t commit_of(input reg_sel_e s);
        commit_t e;
        e = '0;
        case (s)
            SEL_CNT_LO: e.cnt_lo = 1'b1;
            SEL_CNT_HI: e.cnt_hi = 1'b1;
            SEL_CMP_LO: e.cmp_lo = 1'b1;
            SEL_CMP_HI: e.cmp_hi = 1'b1;
            SEL_STEP:   e.step   = 1'b1;
            SEL_CTRL:   e.ctrl   = 1'b1;
            default:    e = '0;
        endcase
        return e;
    endfunction

    function automatic logic [HALF_W-1:0] ack_word(input commit_t s);
        logic [HALF_W-1:0] w;
        w = '0;
        w[ACK_CTRL_BIT]  = s.ctrl;
        w[ACK_STEP_BIT]  = s.step;
        w[ACK_CMPHI_BIT] = s.cmp_hi;
        w[ACK_CMPLO_BIT] = s.cmp_lo;
        return w;
    endfunction

    function automatic logic [HALF_W-1:0] cnt_ack_word(input commit_t s);
        logic [HALF_W-1:0] w;
        w = '0;
        w[1] = s.cnt_hi;
        w[0] = s.cnt_lo;
        return w;
    endfunction

endpackage

// File: rtl/wtt_counter.sv
module wtt_counter
    import wtt_pkg::*;
#(
    parameter int HW = HALF_W,
    parameter int NH = N_HALVES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [NH-1:0]     wr_half,
    input  logic [HW-1:0]     wdata,
    output logic [HW*NH-1:0]  count
);

    localparam int TOT_W = HW * NH;

    logic [TOT_W-1:0] plus_one;
    logic             any_wr;
    logic [HW-1:0]    half_q [NH];

    assign plus_one = count + {{(TOT_W-1){1'b0}}, 1'b1};
    assign any_wr   = |wr_half;

    for (genvar h = 0; h < NH; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                half_q[h] <= '0;
            end else if (wr_half[h]) begin
                half_q[h] <= wdata;
            end else if (run && !any_wr) begin
                half_q[h] <= plus_one[h*HW +: HW];
            end
        end
        assign count[h*HW +: HW] = half_q[h];
    end

endmodule

// File: rtl/wtt_compare.sv
module wtt_compare
    import wtt_pkg::*;
#(
    parameter int HW = HALF_W,
    parameter int NH = N_HALVES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HW*NH-1:0]  count,
    input  logic              cmp_en,
    input  logic              auto_inc,
    input  logic [NH-1:0]     wr_half,
    input  logic              wr_step,
    input  logic              flag_clr,
    input  logic [HW-1:0]     wdata,
    output logic [HW*NH-1:0]  cmp_val,
    output logic [HW-1:0]     step,
    output logic              match,
    output logic              flag
);

    localparam int TOT_W = HW * NH;

    logic [TOT_W-1:0] advanced;

    assign match    = cmp_en && (count == cmp_val);
    assign advanced = cmp_val + {{(TOT_W-HW){1'b0}}, step};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val <= '0;
        end else if (|wr_half) begin
            // software write wins over the automatic advance
            for (int h = 0; h < NH; h++) begin
                if (wr_half[h]) cmp_val[h*HW +: HW] <= wdata;
            end
        end else if (match && auto_inc) begin
            cmp_val <= advanced;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= '0;
        end else if (wr_step) begin
            step <= wdata;
        end
    end

    // a new match outranks a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (match) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wtt_commit.sv
module wtt_commit
    import wtt_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  commit_t evt,
    input  commit_t clr,
    output commit_t stat
);

    commit_t pipe [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= evt;
            for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
        end
    end

    // arriving set outranks a same-edge clear
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~clr) | pipe[LAT-1];
        end
    end

endmodule

// File: rtl/wide_tick_timer.sv
module wide_tick_timer
    import wtt_pkg::*;
#(
    parameter int COMMIT_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);

    reg_sel_e             sel;
    ctrl_t                ctrl_q;
    logic                 mask_q;
    logic [CNT_W-1:0]     count;
    logic [CNT_W-1:0]     cmp_val;
    logic [HALF_W-1:0]    cmp_step;
    logic                 cmp_match;
    logic                 irq_flag;
    logic [N_HALVES-1:0]  cnt_wr;
    logic [N_HALVES-1:0]  cmp_wr;
    logic                 run_en;
    logic                 cmp_en;
    logic                 auto_inc;
    commit_t              evt;
    commit_t              clr;
    commit_t              ack_stat;

    assign sel      = decode_addr(bus_addr);
    assign run_en   = ctrl_q.run;
    assign cmp_en   = ctrl_q.cmp_en;
    assign auto_inc = ctrl_q.auto_inc;

    assign cnt_wr = {bus_we && (sel == SEL_CNT_HI), bus_we && (sel == SEL_CNT_LO)};
    assign cmp_wr = {bus_we && (sel == SEL_CMP_HI), bus_we && (sel == SEL_CMP_LO)};

    assign evt = bus_we ? commit_of(sel) : '0;

    always_comb begin
        clr = '0;
        if (bus_we && sel == SEL_CNT_ACK) begin
            clr.cnt_lo = bus_wdata[0];
            clr.cnt_hi = bus_wdata[1];
        end
        if (bus_we && sel == SEL_ACK) begin
            clr.cmp_lo = bus_wdata[ACK_CMPLO_BIT];
            clr.cmp_hi = bus_wdata[ACK_CMPHI_BIT];
            clr.step   = bus_wdata[ACK_STEP_BIT];
            clr.ctrl   = bus_wdata[ACK_CTRL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= 1'b0;
        end else if (bus_we) begin
            if (sel == SEL_CTRL) ctrl_q <= ctrl_from_word(bus_wdata);
            if (sel == SEL_MASK) mask_q <= bus_wdata[0];
        end
    end

    wtt_counter #(.HW(HALF_W), .NH(N_HALVES)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .run     (run_en),
        .wr_half (cnt_wr),
        .wdata   (bus_wdata),
        .count   (count)
    );

    wtt_compare #(.HW(HALF_W), .NH(N_HALVES)) u_compare (
        .clk      (clk),
        .rst      (rst),
        .count    (count),
        .cmp_en   (cmp_en),
        .auto_inc (auto_inc),
        .wr_half  (cmp_wr),
        .wr_step  (bus_we && (sel == SEL_STEP)),
        .flag_clr (bus_we && (sel == SEL_FLAG) && bus_wdata[0]),
        .wdata    (bus_wdata),
        .cmp_val  (cmp_val),
        .step     (cmp_step),
        .match    (cmp_match),
        .flag     (irq_flag)
    );

    wtt_commit #(.LAT(COMMIT_LAT)) u_commit (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .clr  (clr),
        .stat (ack_stat)
    );

    always_comb begin
        case (sel)
            SEL_CNT_LO:  bus_rdata = count[HALF_W-1:0];
            SEL_CNT_HI:  bus_rdata = count[CNT_W-1:HALF_W];
            SEL_CNT_ACK: bus_rdata = cnt_ack_word(ack_stat);
            SEL_CMP_LO:  bus_rdata = cmp_val[HALF_W-1:0];
            SEL_CMP_HI:  bus_rdata = cmp_val[CNT_W-1:HALF_W];
            SEL_STEP:    bus_rdata = cmp_step;
            SEL_CTRL:    bus_rdata = ctrl_to_word(ctrl_q);
            SEL_FLAG:    bus_rdata = {{(HALF_W-1){1'b0}}, irq_flag};
            SEL_MASK:    bus_rdata = {{(HALF_W-1){1'b0}}, mask_q};
            SEL_ACK:     bus_rdata = ack_word(ack_stat);
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = irq_flag & mask_q;

endmodule

// File: rtl/wtt_checker.sv
module wtt_checker
    import wtt_pkg::*;
#(
    parameter int LAT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              clr_bit,
    input logic [CNT_W-1:0]  count,
    input logic              run_en,
    input logic              match,
    input logic              flag,
    input logic [CNT_W-1:0]  cmp_val,
    input logic [HALF_W-1:0] step,
    input logic              auto_inc,
    input logic              lo_ack
);

    logic             cnt_write;
    logic             cmp_write;
    logic [CNT_W-1:0] step_wide;

    assign cnt_write = bus_we && (bus_addr == OFS_CNT_LO || bus_addr == OFS_CNT_HI);
    assign cmp_write = bus_we && (bus_addr == OFS_CMP_LO || bus_addr == OFS_CMP_HI);
    assign step_wide = {{(CNT_W-HALF_W){1'b0}}, step};

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !cnt_write) |=> $stable(count));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && !cnt_write) |=> (count == $past(count) + {{(CNT_W-1){1'b0}}, 1'b1}));

    // R8
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_FLAG && clr_bit && !match) |=> !flag);

    // R11
    auto_step_chk: assert property (@(posedge clk) disable iff (rst)
        (match && auto_inc && !cmp_write) |=> (cmp_val == $past(cmp_val) + $past(step_wide)));

    if (LAT == 2) begin : g_lat2
        // R5
        commit_delay_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == OFS_CMP_LO) |=> ##2 lo_ack);
    end

endmodule

bind wide_tick_timer wtt_checker #(.LAT(COMMIT_LAT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .clr_bit  (bus_wdata[0]),
    .count    (count),
    .run_en   (run_en),
    .match    (cmp_match),
    .flag     (irq_flag),
    .cmp_val  (cmp_val),
    .step     (cmp_step),
    .auto_inc (auto_inc),
    .lo_ack   (ack_stat.cmp_lo)
);

// File: tb/tb_wide_tick_timer.sv
module tb_wide_tick_timer;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 11;

    localparam logic [11:0] A_CNT_LO  = 12'h100;
    localparam logic [11:0] A_CNT_HI  = 12'h104;
    localparam logic [11:0] A_CNT_ACK = 12'h110;
    localparam logic [11:0] A_CMP_LO  = 12'h200;
    localparam logic [11:0] A_CMP_HI  = 12'h204;
    localparam logic [11:0] A_STEP    = 12'h208;
    localparam logic [11:0] A_CTRL    = 12'h240;
    localparam logic [11:0] A_FLAG    = 12'h244;
    localparam logic [11:0] A_MASK    = 12'h248;
    localparam logic [11:0] A_ACK     = 12'h24C;

    // {address, write data, expected read-back} for R2
    localparam logic [75:0] VECS [N_VEC] = '{
        {12'h200, 32'hA5A5_1234, 32'hA5A5_1234},
        {12'h204, 32'h0F0F_8001, 32'h0F0F_8001},
        {12'h208, 32'h0000_0040, 32'h0000_0040},
        {12'h240, 32'hFFFF_FEFC, 32'h0000_0000},
        {12'h240, 32'h0000_00FE, 32'h0000_0002},
        {12'h248, 32'hFFFF_FFFE, 32'h0000_0000},
        {12'h248, 32'h0000_0001, 32'h0000_0001},
        {12'h300, 32'hDEAD_BEEF, 32'h0000_0000},
        {12'h0FC, 32'h1234_5678, 32'h0000_0000},
        {12'h100, 32'h0000_0777, 32'h0000_0777},
        {12'h104, 32'h8000_0000, 32'h8000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    wide_tick_timer dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives in the low phase; returns at the falling edge after the write edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(A_CNT_LO, v);  check("R1 cnt_lo", v, 32'h0);
        rd(A_CTRL, v);    check("R1 ctrl", v, 32'h0);
        rd(A_FLAG, v);    check("R1 flag", v, 32'h0);
        rd(A_ACK, v);     check("R1 ack", v, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        cyc(4);
        rd(A_CNT_LO, v);  check("R1 stopped", v, 32'h0);

        // R2: register table
        for (int i = 0; i < N_VEC; i++) begin
            wr(VECS[i][75:64], VECS[i][63:32]);
            rd(VECS[i][75:64], v);
            check("R2 readback", v, VECS[i][31:0]);
        end
        wr(A_CTRL, 32'h0);
        wr(A_MASK, 32'h0);
        cyc(3);
        wr(A_CNT_ACK, 32'hFFFF_FFFF);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd(A_ACK, v);     check("R6 clear all", v, 32'h0);
        rd(A_CNT_ACK, v); check("R6 clear cnt", v, 32'h0);

        // R3: load while stopped, then hold
        wr(A_CNT_LO, 32'hFFFF_FFFE);
        wr(A_CNT_HI, 32'h0000_0001);
        cyc(4);
        rd(A_CNT_LO, v);  check("R3 lo held", v, 32'hFFFF_FFFE);
        rd(A_CNT_HI, v);  check("R3 hi held", v, 32'h1);
        rd(A_CNT_ACK, v); check("R5 cnt commit bits", v, 32'h3);
        wr(A_CNT_ACK, 32'h1);
        rd(A_CNT_ACK, v); check("R6 partial clear", v, 32'h2);
        wr(A_CNT_ACK, 32'h2);

        // R4: carry from low into high
        wr(A_CTRL, 32'h100);
        cyc(2);
        rd(A_CNT_HI, v);  check("R4 carry hi", v, 32'h2);
        rd(A_CNT_LO, v);  check("R4 carry lo", v, 32'h0);
        wr(A_CTRL, 32'h0);
        cyc(3);
        rd(A_CNT_LO, v);  check("R3 stop holds", v, 32'h1);

        // R4: full 64-bit wrap
        wr(A_CNT_LO, 32'hFFFF_FFFF);
        wr(A_CNT_HI, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h100);
        rd(A_CNT_LO, v);  check("R4 before wrap", v, 32'hFFFF_FFFF);
        cyc(1);
        rd(A_CNT_LO, v);  check("R4 wrap lo", v, 32'h0);
        rd(A_CNT_HI, v);  check("R4 wrap hi", v, 32'h0);
        wr(A_CTRL, 32'h0);
        cyc(3);
        wr(A_CNT_ACK, 32'h3);
        wr(A_ACK, 32'hFFFF_FFFF);

        // R5: exact commit latency
        wr(A_CMP_LO, 32'h0);
        rd(A_ACK, v);     check("R5 edge+1", v, 32'h0);
        cyc(1);
        rd(A_ACK, v);     check("R5 edge+2 before", v, 32'h0);
        cyc(1);
        rd(A_ACK, v);     check("R5 set", v, 32'h1);

        // R6: set and clear on the same edge, set wins
        wr(A_CMP_HI, 32'h0);
        cyc(1);
        wr(A_ACK, 32'h2);
        rd(A_ACK, v);     check("R6 set wins", v, 32'h3);
        wr(A_ACK, 32'h3);
        rd(A_ACK, v);     check("R6 cleared", v, 32'h0);

        // R5: step and control bits
        wr(A_STEP, 32'h0);
        wr(A_CTRL, 32'h0);
        cyc(3);
        rd(A_ACK, v);     check("R5 step ctrl bits", v, 32'h0001_0004);
        wr(A_ACK, 32'h0001_0004);

        // R7: registers without a commit bit
        wr(A_MASK, 32'h0);
        wr(A_FLAG, 32'h0);
        wr(A_CNT_ACK, 32'h0);
        wr(A_ACK, 32'h0);
        wr(12'h300, 32'h1);
        cyc(3);
        rd(A_ACK, v);     check("R7 ack", v, 32'h0);
        rd(A_CNT_ACK, v); check("R7 cnt ack", v, 32'h0);

        // R12: comparator disabled
        wr(A_CNT_LO, 32'h0);
        wr(A_CNT_HI, 32'h0);
        wr(A_CMP_LO, 32'h3);
        wr(A_CMP_HI, 32'h0);
        wr(A_MASK, 32'h1);
        wr(A_CTRL, 32'h100);
        cyc(8);
        rd(A_FLAG, v);    check("R12 no flag", v, 32'h0);
        check("R12 no irq", {31'd0, irq}, 32'h0);
        wr(A_CTRL, 32'h0);

        // R8 / R9 / R10: one-shot match
        wr(A_CNT_LO, 32'd100);
        wr(A_CNT_HI, 32'h0);
        wr(A_CMP_LO, 32'd105);
        wr(A_CMP_HI, 32'h0);
        wr(A_MASK, 32'h1);
        wr(A_CTRL, 32'h101);
        cyc(5);
        check("R8 before match", {31'd0, irq}, 32'h0);
        cyc(1);
        check("R8 irq", {31'd0, irq}, 32'h1);
        rd(A_FLAG, v);    check("R8 flag", v, 32'h1);
        cyc(4);
        check("R9 level held", {31'd0, irq}, 32'h1);
        wr(A_MASK, 32'h0);
        check("R9 masked irq", {31'd0, irq}, 32'h0);
        rd(A_FLAG, v);    check("R9 flag kept", v, 32'h1);
        wr(A_FLAG, 32'h1);
        rd(A_FLAG, v);    check("R10 cleared", v, 32'h0);
        wr(A_CTRL, 32'h0);

        // R11 / R10: periodic re-arm and same-edge clear
        wr(A_CNT_LO, 32'h0);
        wr(A_CNT_HI, 32'h0);
        wr(A_CMP_LO, 32'd10);
        wr(A_CMP_HI, 32'h0);
        wr(A_STEP, 32'd10);
        wr(A_MASK, 32'h1);
        wr(A_CTRL, 32'h103);
        cyc(10);
        rd(A_CMP_LO, v);  check("R11 before", v, 32'd10);
        check("R11 irq before", {31'd0, irq}, 32'h0);
        cyc(1);
        rd(A_CMP_LO, v);  check("R11 advanced", v, 32'd20);
        check("R11 irq", {31'd0, irq}, 32'h1);
        cyc(9);
        wr(A_FLAG, 32'h1);
        rd(A_FLAG, v);    check("R10 match wins", v, 32'h1);
        rd(A_CMP_LO, v);  check("R11 second", v, 32'd30);
        wr(A_FLAG, 32'h1);
        rd(A_FLAG, v);    check("R10 later clear", v, 32'h0);
        cyc(8);
        check("R11 gap", {31'd0, irq}, 32'h0);
        cyc(1);
        check("R11 third irq", {31'd0, irq}, 32'h1);
        rd(A_CMP_LO, v);  check("R11 third", v, 32'd40);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule